// File: doc/BRIEF.md
# Bus-master IDE DMA channel

This block is one channel of a bus-master disk DMA engine. Host software programs it through a small byte-offset register window. It writes the base address of a descriptor table, picks a direction, and then sets the run bit. The run bit may be set at any point after the disk command has gone out. The engine then walks the descriptor table through a memory request port. Each descriptor holds an address word and a count word. For each descriptor, the engine moves that many bytes between memory and a byte stream on the device side.

Completion and faults are reported in a status byte. The error and interrupt flags there are cleared by writing one to them. Two per-drive capability flags in the same byte are plain storage.

Every data interface uses a valid/ready handshake. A request or byte, once offered with valid high, keeps its payload unchanged until ready is sampled high. The one exception is when software clears the run bit, which withdraws the offer at once. Memory responses carry no ready: the memory returns exactly one response per accepted request, and the channel always takes it. Only one memory request is ever in flight.

Top module: `bmdma_channel`

## Requirements
- R1: Register offsets: the command byte is at offset 0, the status byte at offset 2, and the table base at offset 4. Offsets 1 and 3 always read zero and ignore writes. The table base reads back with bits 1:0 forced to zero.
- R2: Setting command bit 0 while it reads 0 makes status bit 0 (active) read 1 from the next cycle. Descriptor fetch then starts. Descriptor k has its address word at base+8k and its count word at base+8k+4, both little-endian 32-bit words, and descriptors are processed in order.
- R3: Command bit 3 is sampled at start. A value of 0 moves bytes from memory to the device output stream. A value of 1 moves bytes from the device input stream into memory. Bytes go to or from consecutive addresses, starting at the descriptor address.
- R4: A count field (bits 15:0 of the count word) of zero means 65536 bytes.
- R5: Bit 31 of a count word marks the last descriptor. Active clears once its final byte has moved, and no byte is written past the end of that region.
- R6: Writing the command byte with bit 0 clear stops the engine. Active reads 0 on the next cycle, and no further byte is moved.
- R7: A high level on dev_intr sets status bit 2 (interrupt) on the next clock edge.
- R8: An error response from memory sets status bit 1 (error) and clears active on the same edge. No data of that beat is passed on.
- R9: Status bits 1 and 2 clear when written with 1, and are unchanged when written with 0. A setting event in the same cycle takes precedence over the clear.
- R10: Status bits 5 and 6 are read/write capability flags that the engine never changes.
- R11: After reset every register reads zero. A good finish reads status bits 2:0 as binary 100, and any other pattern is a failed transfer.
- R12: mem_req_valid and dev_out_valid, once high, keep their address, direction and data stable until the matching ready is seen. The one exception is a stop command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| dev_intr | input | 1 | Device interrupt level |
| mem_req_valid | output | 1 | Memory request offered |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = byte write, 0 = read |
| mem_req_addr | output | ADDR_W | Request byte address |
| mem_req_wdata | output | 8 | Byte to write |
| mem_rsp_valid | input | 1 | Response present |
| mem_rsp_rdata | input | 32 | Read data (byte reads use bits 7:0) |
| mem_rsp_err | input | 1 | Response is an error |
| dev_in_valid | input | 1 | Device byte offered |
| dev_in_ready | output | 1 | Channel takes the device byte |
| dev_in_data | input | 8 | Device byte |
| dev_out_valid | output | 1 | Byte offered to the device |
| dev_out_ready | input | 1 | Device takes the byte |
| dev_out_data | output | 8 | Byte for the device |

## Verification
The hardest state to reach from the ports is a descriptor whose count field is zero. Running it to completion would take far more cycles than a run allows. The stimulus instead lets such a transfer stream for several hundred cycles and checks that the engine is still active after well over a hundred bytes. It then clears the run bit in the middle of the transfer. This one scenario shows that the count is taken as large rather than empty, and that the stop takes effect on the next cycle with nothing moving afterwards. A memory model that stalls its ready line on a fixed pattern and can return an error for one chosen address drives the fault path.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  typedef enum logic [3:0] {
    E_IDLE, E_A_REQ, E_A_RSP, E_C_REQ, E_C_RSP,
    E_D_IN, E_M_REQ, E_M_RSP, E_D_OUT
  } eng_state_t;

  localparam logic [2:0] OFS_CMD  = 3'd0;
  localparam logic [2:0] OFS_VND0 = 3'd1;
  localparam logic [2:0] OFS_STAT = 3'd2;
  localparam logic [2:0] OFS_VND1 = 3'd3;
  localparam logic [2:0] OFS_BASE = 3'd4;

  localparam int CMD_RUN   = 0;
  localparam int CMD_TOMEM = 3;
  localparam int STS_ACT   = 0;
  localparam int STS_ERR   = 1;
  localparam int STS_IRQ   = 2;
  localparam int STS_CAP0  = 5;
  localparam int STS_CAP1  = 6;
  localparam int LAST_BIT  = 31;
endpackage

// File: rtl/bmdma_regs.sv
module bmdma_regs
  import bmdma_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              busy,
  input  logic              err_evt,
  input  logic              irq_in,
  output logic              run_pulse,
  output logic              halt_pulse,
  output logic              to_mem,
  output logic [ADDR_W-1:2] tbl_base,
  output logic              err_flag,
  output logic              irq_flag,
  output logic [1:0]        caps
);
  logic run_q;
  logic cmd_wr, stat_wr, base_wr;

  assign cmd_wr  = wr_en && (addr == OFS_CMD);
  assign stat_wr = wr_en && (addr == OFS_STAT);
  assign base_wr = wr_en && (addr == OFS_BASE);

  // a start is a 0->1 change of the run bit; any write with run clear stops
  assign run_pulse  = cmd_wr && wdata[CMD_RUN] && !run_q;
  assign halt_pulse = cmd_wr && !wdata[CMD_RUN];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      to_mem   <= 1'b0;
      tbl_base <= '0;
      err_flag <= 1'b0;
      irq_flag <= 1'b0;
      caps     <= 2'b00;
    end else begin
      if (cmd_wr) begin
        run_q  <= wdata[CMD_RUN];
        to_mem <= wdata[CMD_TOMEM];
      end
      if (base_wr) tbl_base <= wdata[ADDR_W-1:2];
      if (stat_wr) caps <= {wdata[STS_CAP1], wdata[STS_CAP0]};
      // setting events win over a write-one clear in the same cycle
      if (err_evt)                        err_flag <= 1'b1;
      else if (stat_wr && wdata[STS_ERR]) err_flag <= 1'b0;
      if (irq_in)                         irq_flag <= 1'b1;
      else if (stat_wr && wdata[STS_IRQ]) irq_flag <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      OFS_CMD: begin
        rdata[CMD_RUN]   = run_q;
        rdata[CMD_TOMEM] = to_mem;
      end
      OFS_STAT: begin
        rdata[STS_ACT]  = busy;
        rdata[STS_ERR]  = err_flag;
        rdata[STS_IRQ]  = irq_flag;
        rdata[STS_CAP0] = caps[0];
        rdata[STS_CAP1] = caps[1];
      end
      OFS_BASE: rdata[ADDR_W-1:0] = {tbl_base, 2'b00};
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/bmdma_engine.sv
module bmdma_engine
  import bmdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_pulse,
  input  logic              halt_pulse,
  input  logic              to_mem,
  input  logic [ADDR_W-1:2] tbl_base,
  output logic              busy,
  output logic              err_evt,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [7:0]        mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_rdata,
  input  logic              mem_rsp_err,
  input  logic              dev_in_valid,
  output logic              dev_in_ready,
  input  logic [7:0]        dev_in_data,
  output logic              dev_out_valid,
  input  logic              dev_out_ready,
  output logic [7:0]        dev_out_data
);
  localparam int REM_W = CNT_W + 1;
  localparam logic [REM_W-1:0] FULL_CNT = {1'b1, {CNT_W{1'b0}}};
  localparam logic [ADDR_W-1:0] DESC_SZ = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] CW_OFS  = ADDR_W'(4);

  eng_state_t        state, after_byte;
  logic [ADDR_W-1:0] fptr, daddr;
  logic [REM_W-1:0]  rem;
  logic              last_ent, dir_l;
  logic [7:0]        hold;
  logic              in_rsp, rsp_ok;

  assign busy          = (state != E_IDLE);
  assign in_rsp        = (state == E_A_RSP) || (state == E_C_RSP) || (state == E_M_RSP);
  assign err_evt       = in_rsp && mem_rsp_valid && mem_rsp_err;
  assign rsp_ok        = mem_rsp_valid && !mem_rsp_err;
  assign mem_req_valid = (state == E_A_REQ) || (state == E_C_REQ) || (state == E_M_REQ);
  assign mem_req_we    = (state == E_M_REQ) && dir_l;
  assign mem_req_wdata = hold;
  assign dev_in_ready  = (state == E_D_IN);
  assign dev_out_valid = (state == E_D_OUT);
  assign dev_out_data  = hold;

  always_comb begin
    case (state)
      E_A_REQ: mem_req_addr = fptr;
      E_C_REQ: mem_req_addr = fptr + CW_OFS;
      default: mem_req_addr = daddr;
    endcase
  end

  // where to go once the current byte has been delivered
  always_comb begin
    if (rem == REM_W'(1)) after_byte = last_ent ? E_IDLE : E_A_REQ;
    else                  after_byte = dir_l ? E_D_IN : E_M_REQ;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= E_IDLE;
      fptr     <= '0;
      daddr    <= '0;
      rem      <= '0;
      last_ent <= 1'b0;
      dir_l    <= 1'b0;
      hold     <= '0;
    end else if (halt_pulse) begin
      state <= E_IDLE;
    end else begin
      case (state)
        E_IDLE: if (run_pulse) begin
          fptr  <= {tbl_base, 2'b00};
          dir_l <= to_mem;
          state <= E_A_REQ;
        end
        E_A_REQ: if (mem_req_ready) state <= E_A_RSP;
        E_A_RSP: if (mem_rsp_valid) begin
          if (mem_rsp_err) state <= E_IDLE;
          else begin
            daddr <= mem_rsp_rdata[ADDR_W-1:0];
            state <= E_C_REQ;
          end
        end
        E_C_REQ: if (mem_req_ready) state <= E_C_RSP;
        E_C_RSP: if (mem_rsp_valid) begin
          if (mem_rsp_err) state <= E_IDLE;
          else begin
            rem      <= (mem_rsp_rdata[CNT_W-1:0] == '0) ? FULL_CNT
                        : {1'b0, mem_rsp_rdata[CNT_W-1:0]};
            last_ent <= mem_rsp_rdata[LAST_BIT];
            fptr     <= fptr + DESC_SZ;
            state    <= dir_l ? E_D_IN : E_M_REQ;
          end
        end
        E_D_IN: if (dev_in_valid) begin
          hold  <= dev_in_data;
          state <= E_M_REQ;
        end
        E_M_REQ: if (mem_req_ready) state <= E_M_RSP;
        E_M_RSP: if (mem_rsp_valid) begin
          if (mem_rsp_err) state <= E_IDLE;
          else if (!dir_l) begin
            hold  <= mem_rsp_rdata[7:0];
            state <= E_D_OUT;
          end else begin
            daddr <= daddr + ADDR_W'(1);
            rem   <= rem - REM_W'(1);
            state <= after_byte;
          end
        end
        E_D_OUT: if (dev_out_ready) begin
          daddr <= daddr + ADDR_W'(1);
          rem   <= rem - REM_W'(1);
          state <= after_byte;
        end
        default: state <= E_IDLE;
      endcase
    end
  end

  logic unused_ok;
  assign unused_ok = rsp_ok;
endmodule

// File: rtl/bmdma_channel.sv
module bmdma_channel #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              dev_intr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [7:0]        mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_rdata,
  input  logic              mem_rsp_err,
  input  logic              dev_in_valid,
  output logic              dev_in_ready,
  input  logic [7:0]        dev_in_data,
  output logic              dev_out_valid,
  input  logic              dev_out_ready,
  output logic [7:0]        dev_out_data
);
  logic              eng_busy, err_evt, run_pulse, halt_pulse, to_mem;
  logic              err_flag, irq_flag;
  logic [1:0]        caps;
  logic [ADDR_W-1:2] tbl_base;

  bmdma_regs #(.ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .busy(eng_busy), .err_evt(err_evt),
    .irq_in(dev_intr), .run_pulse(run_pulse), .halt_pulse(halt_pulse),
    .to_mem(to_mem), .tbl_base(tbl_base), .err_flag(err_flag),
    .irq_flag(irq_flag), .caps(caps)
  );

  bmdma_engine #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) eng_i (
    .clk(clk), .rst_n(rst_n), .run_pulse(run_pulse), .halt_pulse(halt_pulse),
    .to_mem(to_mem), .tbl_base(tbl_base), .busy(eng_busy), .err_evt(err_evt),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata), .mem_rsp_err(mem_rsp_err),
    .dev_in_valid(dev_in_valid), .dev_in_ready(dev_in_ready),
    .dev_in_data(dev_in_data), .dev_out_valid(dev_out_valid),
    .dev_out_ready(dev_out_ready), .dev_out_data(dev_out_data)
  );
endmodule

// File: rtl/bmdma_channel_chk.sv
module bmdma_channel_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_en,
  input logic [2:0]        reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              dev_intr,
  input logic              busy,
  input logic              err_evt,
  input logic              err_flag,
  input logic              irq_flag,
  input logic [1:0]        caps,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_we,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [7:0]        mem_req_wdata,
  input logic              dev_out_valid,
  input logic              dev_out_ready,
  input logic [7:0]        dev_out_data
);
  logic halt_w, stat_w;
  assign halt_w = reg_wr_en && (reg_addr == 3'd0) && !reg_wdata[0];
  assign stat_w = reg_wr_en && (reg_addr == 3'd2);

  // R12
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready && !halt_w) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we) && $stable(mem_req_wdata)));

  // R12
  dev_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_out_valid && !dev_out_ready && !halt_w) |=> (dev_out_valid && $stable(dev_out_data)));

  // R6
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_w |=> (!busy && !mem_req_valid && !dev_out_valid));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid);

  // R8
  err_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> !busy);

  // R9
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_w && reg_wdata[1] && !err_evt) |=> !err_flag);

  // R9
  err_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !(stat_w && reg_wdata[1])) |=> err_flag);

  // R7
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_intr |=> irq_flag);

  // R10
  caps_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_w |=> $stable(caps));
endmodule

bind bmdma_channel bmdma_channel_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .dev_intr(dev_intr), .busy(eng_busy),
  .err_evt(err_evt), .err_flag(err_flag), .irq_flag(irq_flag), .caps(caps),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
  .mem_req_wdata(mem_req_wdata), .dev_out_valid(dev_out_valid),
  .dev_out_ready(dev_out_ready), .dev_out_data(dev_out_data)
);

// File: tb/bmdma_channel_tb.sv
module bmdma_channel_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        dev_intr = 1'b0;
  logic        mem_req_valid, mem_req_ready, mem_req_we;
  logic [31:0] mem_req_addr;
  logic [7:0]  mem_req_wdata;
  logic        mem_rsp_valid, mem_rsp_err;
  logic [31:0] mem_rsp_rdata;
  logic        dev_in_valid, dev_in_ready;
  logic [7:0]  dev_in_data;
  logic        dev_out_valid, dev_out_ready;
  logic [7:0]  dev_out_data;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bmdma_channel dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dev_intr(dev_intr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata), .mem_rsp_err(mem_rsp_err),
    .dev_in_valid(dev_in_valid), .dev_in_ready(dev_in_ready),
    .dev_in_data(dev_in_data), .dev_out_valid(dev_out_valid),
    .dev_out_ready(dev_out_ready), .dev_out_data(dev_out_data)
  );

  // free-running cycle counter for stall patterns
  logic [7:0] cyc = 8'd0;
  always @(posedge clk) cyc <= cyc + 8'd1;

  // memory model: one response per accepted request, optional error address
  logic [7:0]  mem [0:4095];
  logic        bd_we = 1'b0;
  logic [11:0] bd_a = 12'd0;
  logic [7:0]  bd_d = 8'd0;
  logic        err_en = 1'b0;
  logic [31:0] err_addr = 32'hFFFF_FFFF;
  assign mem_req_ready = (cyc[1:0] != 2'b01);

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    mem_rsp_err   <= 1'b0;
    if (!rst_n) begin
      for (int i = 0; i < 4096; i++) mem[i] <= 8'h55;
      mem_rsp_rdata <= 32'd0;
    end else begin
      if (bd_we) mem[bd_a] <= bd_d;
      if (mem_req_valid && mem_req_ready) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_err   <= err_en && (mem_req_addr == err_addr);
        mem_rsp_rdata <= {mem[mem_req_addr[11:0] + 12'd3], mem[mem_req_addr[11:0] + 12'd2],
                          mem[mem_req_addr[11:0] + 12'd1], mem[mem_req_addr[11:0]]};
        if (mem_req_we && !(err_en && (mem_req_addr == err_addr)))
          mem[mem_req_addr[11:0]] <= mem_req_wdata;
      end
    end
  end

  // device source: counting bytes; device sink: logs bytes, stalls every third cycle
  int src_cnt = 0;
  int sink_cnt = 0;
  logic [7:0] sink_buf [0:255];
  assign dev_in_valid  = 1'b1;
  assign dev_in_data   = 8'hA0 + src_cnt[7:0];
  assign dev_out_ready = ((cyc % 8'd3) != 8'd0);
  always @(posedge clk) begin
    if (dev_in_valid && dev_in_ready) src_cnt <= src_cnt + 1;
    if (dev_out_valid && dev_out_ready) begin
      sink_buf[sink_cnt[7:0]] <= dev_out_data;
      sink_cnt <= sink_cnt + 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic poke(input int a, input logic [7:0] d);
    @(negedge clk);
    bd_we = 1'b1; bd_a = a[11:0]; bd_d = d;
    @(negedge clk);
    bd_we = 1'b0;
  endtask

  task automatic poke_word(input int a, input logic [31:0] w);
    for (int k = 0; k < 4; k++) poke(a + k, w[8*k +: 8]);
  endtask

  task automatic wait_idle(input string tag);
    logic [31:0] s;
    int n = 0;
    do begin
      rd(3'd2, s);
      n++;
    end while (s[0] && n < 2000);
    check({tag, " engine reached idle"}, {31'd0, s[0]}, 32'd0);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(3'd0, v); check("R11 reset command", v, 32'h0);
    rd(3'd2, v); check("R11 reset status", v, 32'h0);
    rd(3'd4, v); check("R11 reset base", v, 32'h0);
  endtask

  task automatic t_regs;
    logic [31:0] v;
    wr(3'd4, 32'h0000_1237);
    rd(3'd4, v); check("R1 base low bits zero", v, 32'h0000_1234);
    wr(3'd1, 32'hFF); wr(3'd3, 32'hFF);
    rd(3'd1, v); check("R1 offset 1 reads zero", v, 32'h0);
    rd(3'd3, v); check("R1 offset 3 reads zero", v, 32'h0);
    wr(3'd2, 32'h60);
    rd(3'd2, v); check("R10 capability flags stored", v, 32'h60);
  endtask

  task automatic t_mem_to_dev;
    logic [31:0] v;
    int s0;
    poke_word(32'h100, 32'h200); poke_word(32'h104, 32'd5);
    poke_word(32'h108, 32'h300); poke_word(32'h10C, 32'h8000_0003);
    for (int i = 0; i < 5; i++) poke(32'h200 + i, 8'h10 + 8'(i));
    for (int i = 0; i < 3; i++) poke(32'h300 + i, 8'h20 + 8'(i));
    wr(3'd4, 32'h100);
    wr(3'd0, 32'h0);
    s0 = sink_cnt;
    wr(3'd0, 32'h1);
    rd(3'd2, v); check("R2 active after start", v, 32'h61);
    rd(3'd0, v); check("R3 command reads run, read direction", v, 32'h1);
    wait_idle("R5 two-entry read");
    check("R5 byte count out", 32'(sink_cnt - s0), 32'd8);
    for (int i = 0; i < 8; i++)
      check("R3 memory-to-device byte", {24'd0, sink_buf[8'(s0 + i)]},
            (i < 5) ? 32'h10 + 32'(i) : 32'h20 + 32'(i - 5));
    rd(3'd2, v); check("R10 caps untouched after transfer", v, 32'h60);
    @(negedge clk); dev_intr = 1'b1; @(negedge clk); dev_intr = 1'b0;
    rd(3'd2, v); check("R7 R11 good completion pattern", v, 32'h64);
    wr(3'd2, 32'h60);
    rd(3'd2, v); check("R9 write zero keeps interrupt", v, 32'h64);
    wr(3'd2, 32'h64);
    rd(3'd2, v); check("R9 write one clears interrupt", v, 32'h60);
  endtask

  task automatic t_dev_to_mem;
    int s0;
    poke_word(32'h180, 32'h400); poke_word(32'h184, 32'h8000_0006);
    wr(3'd4, 32'h180);
    wr(3'd0, 32'h8);
    s0 = src_cnt;
    wr(3'd0, 32'h9);
    wait_idle("R3 device-to-memory");
    for (int i = 0; i < 6; i++)
      check("R3 device byte stored", {24'd0, mem[12'h400 + 12'(i)]}, {24'd0, 8'hA0 + 8'(s0 + i)});
    check("R5 no write past region", {24'd0, mem[12'h406]}, 32'h55);
  endtask

  task automatic t_abort;
    logic [31:0] v;
    int s0, s1;
    poke_word(32'h1C0, 32'h800); poke_word(32'h1C4, 32'h8000_0000);
    wr(3'd4, 32'h1C0);
    wr(3'd0, 32'h0);
    s0 = sink_cnt;
    wr(3'd0, 32'h1);
    repeat (600) @(negedge clk);
    rd(3'd2, v); check("R4 zero count still active", {31'd0, v[0]}, 32'd1);
    check("R4 more than 100 bytes moved", {31'd0, (sink_cnt - s0) > 100}, 32'd1);
    wr(3'd0, 32'h0);
    rd(3'd2, v); check("R6 stop clears active", {31'd0, v[0]}, 32'd0);
    s1 = sink_cnt;
    repeat (50) @(negedge clk);
    check("R6 nothing moves after stop", 32'(sink_cnt - s1), 32'd0);
  endtask

  task automatic t_error;
    logic [31:0] v;
    int s0;
    poke_word(32'h1E0, 32'h900); poke_word(32'h1E4, 32'h8000_0004);
    @(negedge clk); err_en = 1'b1; err_addr = 32'h900;
    wr(3'd4, 32'h1E0);
    wr(3'd0, 32'h0);
    s0 = sink_cnt;
    wr(3'd0, 32'h1);
    wait_idle("R8 error ends transfer");
    rd(3'd2, v); check("R8 R11 error status pattern", v, 32'h62);
    check("R8 no byte passed on", 32'(sink_cnt - s0), 32'd0);
    wr(3'd2, 32'h62);
    rd(3'd2, v); check("R9 write one clears error", v, 32'h60);
    @(negedge clk); err_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_mem_to_dev();
    t_dev_to_mem();
    t_abort();
    t_error();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(10 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule